// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block manages the power modes of a small 8-bit microcontroller core. Software writes a power control register through a simple single-cycle write port. Setting the idle request bit halts the CPU clock, and setting the power-down request bit stops every clock except, optionally, the 32 kHz oscillator. While the block holds a mode, it drives clock-enable and hold-in-reset outputs for the CPU, Timer 2, the PWM units, the ADC, the always-on peripheral group and both oscillators.

The block watches interrupt requests, their enables, their priority level and the in-service state of both priority levels, and each mode has its own set of wake sources. It also filters the external reset pin and takes a watchdog reset. Each reset source, after its own acceptance rule, places the core in a timed restart phase that clears the control register.

Interrupt sources are indexed 0..6 as X0, T0, X1, SEC, T1, S0, S1. Each has a one-bit priority, where 1 means high.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After a synchronous reset the mode is RUN (mode_oh = 4'b0001), ctl_q reads 0, all clock enables are 1 and no hold is asserted. mode_oh bits are RUN=0, IDLE=1, PDOWN=2, RESTART=3, and exactly one bit is set at all times.
- R2: A write in RUN with data bit 0 set and bit 1 clear enters IDLE on that edge. In IDLE, cpu_clk_en and t2_clk_en are 0, t2_hold_rst, pwm_hold_rst and adc_abort are 1, and periph_clk_en, hf_osc_en and osc32_en stay 1.
- R3: IDLE ends at the next edge when some source has request and enable set and is not blocked. A source is blocked when a high-priority interrupt is in service, or when it is low priority and a low-priority interrupt is in service. On exit ctl_q bit 0 clears.
- R4: A write with bit 1 set enters PDOWN only while wdt_en is 0. Otherwise bit 1 is not stored, and bit 0 alone decides whether IDLE is entered. When bit 1 is accepted it takes precedence over bit 0, and bit 0 reads back as 0.
- R5: In PDOWN, cpu, Timer 2 and peripheral clocks and hf_osc_en are 0. osc32_en is 1 only when sel_hf is 0 and ctl_q bit 4 (32 kHz keep-alive) is 1.
- R6: Only enabled requests from X0, X1 and SEC wake PDOWN. T0, T1, S0 and S1 do not. On wake the mode returns to RUN and ctl_q bit 1 clears.
- R7: If either in-service input was set when the power-down write occurred, interrupt wake is refused for that whole PDOWN stay.
- R8: With sel_hf = 1, an external reset is accepted on the HF_RST_CYC-th consecutive edge at which ext_rst is high, and not earlier.
- R9: With sel_hf = 0, an external reset pulse is accepted at the edge where ext_rst is first seen low, and only if its high width lies in PLL_RST_MIN..PLL_RST_MAX edges.
- R10: An accepted reset moves to RESTART and clears ctl_q. The restart lasts WDT_RESTART_CYC cycles for a watchdog reset, HF_RESTART_CYC for an external reset with sel_hf = 1, and PLL_RESTART_CYC with sel_hf = 0. It then returns to RUN.
- R11: Writes are ignored in every mode other than RUN.
- R12: The flag bits (ctl_q bits 2 and 3) written with the idle request keep their values through IDLE and after the exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Power control register write strobe |
| wr_data | input | 8 | Write data (bit0 idle, bit1 power-down, bits 2-3 flags, bit4 32 kHz keep-alive) |
| wdt_en | input | 1 | Watchdog timer enabled |
| wdt_rst | input | 1 | Watchdog reset pulse |
| ext_rst | input | 1 | External reset pin level |
| sel_hf | input | 1 | 1 = HF oscillator selected, 0 = PLL source |
| irq_req | input | NSRC | Interrupt requests |
| irq_en | input | NSRC | Interrupt enables |
| irq_prio | input | NSRC | Interrupt priority (1 = high) |
| insvc_lo | input | 1 | A low-priority interrupt is in service |
| insvc_hi | input | 1 | A high-priority interrupt is in service |
| ctl_q | output | 8 | Power control register contents |
| mode_oh | output | 4 | One-hot mode |
| cpu_clk_en | output | 1 | CPU clock enable |
| t2_clk_en | output | 1 | Timer 2 clock enable |
| t2_hold_rst | output | 1 | Timer 2 held in reset |
| pwm_hold_rst | output | 1 | PWM units held in reset, outputs high |
| adc_abort | output | 1 | ADC conversion aborted, clock off |
| periph_clk_en | output | 1 | Clock for timers 0/1, watchdog, UART, I2C, external interrupts, seconds timer |
| hf_osc_en | output | 1 | HF oscillator enable |
| osc32_en | output | 1 | 32 kHz oscillator enable |
| core_rst | output | 1 | Core held in reset (restart phase) |

## Verification
The bench builds the block with PLL_RST_MAX = 40, PLL_RESTART_CYC = 20 and HF_RESTART_CYC = 12, and keeps HF_RST_CYC = 24, PLL_RST_MIN = 4 and WDT_RESTART_CYC = 36. This makes the whole PLL reset window reachable in a few dozen cycles: pulses that are too short, in range and too long are all tried. It also lets each restart length be counted exactly. The smaller values leave room for many randomized idle and power-down wake trials, and these cover the priority-blocking rule and the refused wake after a power-down entered from a service routine.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;
  localparam int CTL_W   = 8;
  localparam int B_IDLE  = 0;
  localparam int B_PD    = 1;
  localparam int B_FLAGA = 2;
  localparam int B_FLAGB = 3;
  localparam int B_RUN32 = 4;
  localparam logic [CTL_W-1:0] WR_MASK = 8'h1F;

  typedef enum logic [3:0] {
    M_RUN     = 4'b0001,
    M_IDLE    = 4'b0010,
    M_PDOWN   = 4'b0100,
    M_RESTART = 4'b1000
  } pmode_e;

  typedef enum logic [1:0] {
    RC_HF  = 2'd0,
    RC_PLL = 2'd1,
    RC_WDT = 2'd2
  } rcause_e;
endpackage

// File: rtl/pwr_ctl_reg.sv
`timescale 1ns/1ps
module pwr_ctl_reg
  import pwr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             wdt_en,
  input  logic             clr_idle,
  input  logic             clr_pd,
  input  logic             clr_all,
  output logic [CTL_W-1:0] ctl_q,
  output logic             idle_take,
  output logic             pd_take
);
  // Power-down needs the watchdog to be off; it then wins over idle.
  assign pd_take   = wr_en && wr_data[B_PD] && !wdt_en;
  assign idle_take = wr_en && wr_data[B_IDLE] && !pd_take;

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q         <= wr_data & WR_MASK;
      ctl_q[B_PD]   <= pd_take;
      ctl_q[B_IDLE] <= idle_take;
    end else begin
      if (clr_idle) ctl_q[B_IDLE] <= 1'b0;
      if (clr_pd)   ctl_q[B_PD]   <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_wake_eval.sv
`timescale 1ns/1ps
module pwr_wake_eval #(
  parameter int NSRC = 7,
  parameter logic [NSRC-1:0] PD_WAKE_MASK = 7'b0001101
) (
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_en,
  input  logic [NSRC-1:0] irq_prio,
  input  logic            insvc_lo,
  input  logic            insvc_hi,
  input  logic            pd_isr,
  output logic            idle_wake,
  output logic            pd_wake
);
  logic [NSRC-1:0] live;
  logic [NSRC-1:0] unblocked;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign live[i]      = irq_req[i] && irq_en[i];
    // same-or-higher level in service blocks the request
    assign unblocked[i] = !insvc_hi && (irq_prio[i] || !insvc_lo);
  end

  assign idle_wake = |(live & unblocked);
  assign pd_wake   = |(live & PD_WAKE_MASK) && !pd_isr;
endmodule

// File: rtl/pwr_rst_filter.sv
`timescale 1ns/1ps
module pwr_rst_filter #(
  parameter int HF_RST_CYC  = 24,
  parameter int PLL_RST_MIN = 4,
  parameter int PLL_RST_MAX = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_rst,
  input  logic sel_hf,
  output logic ext_accept
);
  localparam int TOPC = ((HF_RST_CYC > PLL_RST_MAX) ? HF_RST_CYC : PLL_RST_MAX) + 1;
  localparam int W    = $clog2(TOPC + 1);
  localparam logic [W-1:0] SAT     = W'(TOPC);
  localparam logic [W-1:0] HF_LAST = W'(HF_RST_CYC - 1);
  localparam logic [W-1:0] LO      = W'(PLL_RST_MIN);
  localparam logic [W-1:0] HI      = W'(PLL_RST_MAX);

  logic [W-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !ext_rst)   hi_cnt <= '0;
    else if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1'b1;
  end

  always_comb begin
    if (sel_hf) ext_accept = ext_rst && (hi_cnt == HF_LAST);
    else        ext_accept = !ext_rst && (hi_cnt >= LO) && (hi_cnt <= HI);
  end
endmodule

// File: rtl/pwr_restart_timer.sv
`timescale 1ns/1ps
module pwr_restart_timer
  import pwr_seq_pkg::*;
#(
  parameter int HF_RESTART_CYC  = 24,
  parameter int PLL_RESTART_CYC = 5000,
  parameter int WDT_RESTART_CYC = 36
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  rcause_e cause,
  output logic    done
);
  localparam int M1   = (HF_RESTART_CYC > PLL_RESTART_CYC) ? HF_RESTART_CYC : PLL_RESTART_CYC;
  localparam int MAXL = (M1 > WDT_RESTART_CYC) ? M1 : WDT_RESTART_CYC;
  localparam int W    = $clog2(MAXL + 1);

  logic [W-1:0] cnt;
  logic [W-1:0] len_m1;

  always_comb begin
    unique case (cause)
      RC_WDT:  len_m1 = W'(WDT_RESTART_CYC - 1);
      RC_PLL:  len_m1 = W'(PLL_RESTART_CYC - 1);
      default: len_m1 = W'(HF_RESTART_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= len_m1;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NSRC            = 7,
  parameter logic [NSRC-1:0] PD_WAKE_MASK = 7'b0001101,
  parameter int HF_RST_CYC      = 24,
  parameter int PLL_RST_MIN     = 4,
  parameter int PLL_RST_MAX     = 2000,
  parameter int HF_RESTART_CYC  = 24,
  parameter int PLL_RESTART_CYC = 5000,
  parameter int WDT_RESTART_CYC = 36
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            wdt_en,
  input  logic            wdt_rst,
  input  logic            ext_rst,
  input  logic            sel_hf,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_en,
  input  logic [NSRC-1:0] irq_prio,
  input  logic            insvc_lo,
  input  logic            insvc_hi,
  output logic [7:0]      ctl_q,
  output logic [3:0]      mode_oh,
  output logic            cpu_clk_en,
  output logic            t2_clk_en,
  output logic            t2_hold_rst,
  output logic            pwm_hold_rst,
  output logic            adc_abort,
  output logic            periph_clk_en,
  output logic            hf_osc_en,
  output logic            osc32_en,
  output logic            core_rst
);
  pmode_e  state_q, state_d;
  logic    pd_isr_q;
  logic    ext_accept, rst_evt, in_run, in_restart;
  logic    idle_take, pd_take, idle_wake, pd_wake, rst_done;
  logic    clr_idle, clr_pd, clr_all, wr_ok;
  rcause_e cause;

  assign in_run     = (state_q == M_RUN);
  assign in_restart = (state_q == M_RESTART);
  assign rst_evt    = (wdt_rst || ext_accept) && !in_restart;
  assign wr_ok      = wr_en && in_run && !rst_evt;
  assign cause      = wdt_rst ? RC_WDT : (sel_hf ? RC_HF : RC_PLL);
  assign clr_all    = rst_evt;
  assign clr_idle   = (state_q == M_IDLE)  && !rst_evt && idle_wake;
  assign clr_pd     = (state_q == M_PDOWN) && !rst_evt && pd_wake;

  pwr_ctl_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_ok), .wr_data(wr_data), .wdt_en(wdt_en),
    .clr_idle(clr_idle), .clr_pd(clr_pd), .clr_all(clr_all),
    .ctl_q(ctl_q), .idle_take(idle_take), .pd_take(pd_take)
  );

  pwr_wake_eval #(.NSRC(NSRC), .PD_WAKE_MASK(PD_WAKE_MASK)) u_wake (
    .irq_req(irq_req), .irq_en(irq_en), .irq_prio(irq_prio),
    .insvc_lo(insvc_lo), .insvc_hi(insvc_hi), .pd_isr(pd_isr_q),
    .idle_wake(idle_wake), .pd_wake(pd_wake)
  );

  pwr_rst_filter #(
    .HF_RST_CYC(HF_RST_CYC), .PLL_RST_MIN(PLL_RST_MIN), .PLL_RST_MAX(PLL_RST_MAX)
  ) u_rstf (
    .clk(clk), .rst(rst), .ext_rst(ext_rst), .sel_hf(sel_hf), .ext_accept(ext_accept)
  );

  pwr_restart_timer #(
    .HF_RESTART_CYC(HF_RESTART_CYC), .PLL_RESTART_CYC(PLL_RESTART_CYC),
    .WDT_RESTART_CYC(WDT_RESTART_CYC)
  ) u_rtmr (
    .clk(clk), .rst(rst), .load(rst_evt), .cause(cause), .done(rst_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      M_RUN: begin
        if (rst_evt)        state_d = M_RESTART;
        else if (pd_take)   state_d = M_PDOWN;
        else if (idle_take) state_d = M_IDLE;
      end
      M_IDLE: begin
        if (rst_evt)        state_d = M_RESTART;
        else if (idle_wake) state_d = M_RUN;
      end
      M_PDOWN: begin
        if (rst_evt)        state_d = M_RESTART;
        else if (pd_wake)   state_d = M_RUN;
      end
      default: begin
        if (rst_done)       state_d = M_RUN;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= M_RUN;
      pd_isr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (in_run && pd_take && !rst_evt) pd_isr_q <= insvc_lo || insvc_hi;
    end
  end

  always_comb begin
    mode_oh       = state_q;
    cpu_clk_en    = in_run;
    t2_clk_en     = in_run;
    t2_hold_rst   = !in_run;
    pwm_hold_rst  = !in_run;
    adc_abort     = !in_run;
    periph_clk_en = in_run || (state_q == M_IDLE);
    hf_osc_en     = (state_q != M_PDOWN);
    osc32_en      = (state_q != M_PDOWN) || (!sel_hf && ctl_q[B_RUN32]);
    core_rst      = in_restart;
  end
endmodule

// File: rtl/pwr_seq_chk.sv
`timescale 1ns/1ps
module pwr_seq_chk #(
  parameter int NSRC = 7,
  parameter logic [NSRC-1:0] PD_WAKE_MASK = 7'b0001101
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [7:0]      wr_data,
  input logic            wdt_en,
  input logic            wdt_rst,
  input logic            ext_rst,
  input logic [NSRC-1:0] irq_req,
  input logic [NSRC-1:0] irq_en,
  input logic            insvc_hi,
  input logic [7:0]      ctl_q,
  input logic [3:0]      mode_oh
);
  // R1
  mode_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(mode_oh) == 1);

  // R2
  idle_from_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_oh[1]) |-> $past(wr_en && wr_data[0]));

  // R4
  pd_blocked_by_wdt_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_oh[0] && wr_en && wr_data[1] && wdt_en) |=> !mode_oh[2]);

  // R6
  pd_holds_without_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_oh[2] && !(|(irq_req & irq_en & PD_WAKE_MASK)) && !wdt_rst && !ext_rst && !$past(ext_rst))
      |=> mode_oh[2]);

  // R3
  idle_blocked_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_oh[1] && insvc_hi && !wdt_rst && !ext_rst && !$past(ext_rst)) |=> mode_oh[1]);

  // R12
  idle_flags_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_oh[1] && !wdt_rst && !ext_rst && !$past(ext_rst)) |=> $stable(ctl_q[7:2]));

  // R10
  restart_clears_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    mode_oh[3] |-> (ctl_q == 8'h00));
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.NSRC(NSRC), .PD_WAKE_MASK(PD_WAKE_MASK)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wdt_en(wdt_en),
  .wdt_rst(wdt_rst), .ext_rst(ext_rst), .irq_req(irq_req), .irq_en(irq_en),
  .insvc_hi(insvc_hi), .ctl_q(ctl_q), .mode_oh(mode_oh)
);

// File: tb/pwr_seq_ctrl_test.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_test;
  localparam int NSRC = 7;
  localparam logic [NSRC-1:0] PDMASK = 7'b0001101;
  localparam int HF_RST = 24, PLL_MIN = 4, PLL_MAX = 40;
  localparam int HF_RS = 12, PLL_RS = 20, WDT_RS = 36;
  localparam logic [3:0] RUN = 4'b0001, IDLE = 4'b0010, PDN = 4'b0100, RSTR = 4'b1000;

  logic clk = 1'b0;
  logic rst, wr_en, wdt_en, wdt_rst, ext_rst, sel_hf, insvc_lo, insvc_hi;
  logic [7:0] wr_data;
  logic [NSRC-1:0] irq_req, irq_en, irq_prio;
  logic [7:0] ctl_q;
  logic [3:0] mode_oh;
  logic cpu_clk_en, t2_clk_en, t2_hold_rst, pwm_hold_rst, adc_abort;
  logic periph_clk_en, hf_osc_en, osc32_en, core_rst;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pwr_seq_ctrl #(
    .NSRC(NSRC), .PD_WAKE_MASK(PDMASK), .HF_RST_CYC(HF_RST), .PLL_RST_MIN(PLL_MIN),
    .PLL_RST_MAX(PLL_MAX), .HF_RESTART_CYC(HF_RS), .PLL_RESTART_CYC(PLL_RS),
    .WDT_RESTART_CYC(WDT_RS)
  ) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wdt_en(wdt_en),
    .wdt_rst(wdt_rst), .ext_rst(ext_rst), .sel_hf(sel_hf), .irq_req(irq_req),
    .irq_en(irq_en), .irq_prio(irq_prio), .insvc_lo(insvc_lo), .insvc_hi(insvc_hi),
    .ctl_q(ctl_q), .mode_oh(mode_oh), .cpu_clk_en(cpu_clk_en), .t2_clk_en(t2_clk_en),
    .t2_hold_rst(t2_hold_rst), .pwm_hold_rst(pwm_hold_rst), .adc_abort(adc_abort),
    .periph_clk_en(periph_clk_en), .hf_osc_en(hf_osc_en), .osc32_en(osc32_en),
    .core_rst(core_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic quiet();
    irq_req = '0; irq_en = '0; irq_prio = '0; insvc_lo = 0; insvc_hi = 0;
  endtask

  function automatic bit exp_idle_wake(logic [NSRC-1:0] rq, logic [NSRC-1:0] en,
                                       logic [NSRC-1:0] pr, logic lo, logic hi);
    bit w = 0;
    for (int i = 0; i < NSRC; i++)
      if (rq[i] && en[i] && !hi && (pr[i] || !lo)) w = 1;
    return w;
  endfunction

  function automatic bit exp_pd_wake(logic [NSRC-1:0] rq, logic [NSRC-1:0] en, bit isr);
    return (|(rq & en & PDMASK)) && !isr;
  endfunction

  // Counts samples spent in RESTART, the current one included.
  task automatic restart_len(output int n);
    n = 0;
    while (mode_oh == RSTR && n < 10000) begin n++; step(); end
  endtask

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int len;
    bit w, isr;
    logic [1:0] fl;
    void'($urandom(32'h5EED_0042));
    rst = 1; wr_en = 0; wr_data = 0; wdt_en = 0; wdt_rst = 0; ext_rst = 0; sel_hf = 1;
    quiet();
    step(3); rst = 0; step();

    // R1 reset state
    chk(mode_oh == RUN, "R1 mode", mode_oh, RUN);
    chk(ctl_q == 8'h00, "R1 ctl", ctl_q, 0);
    chk({cpu_clk_en, t2_clk_en, periph_clk_en, hf_osc_en, osc32_en} == 5'h1F &&
        {t2_hold_rst, pwm_hold_rst, adc_abort, core_rst} == 4'h0, "R1 outs",
        {cpu_clk_en, t2_clk_en, periph_clk_en, hf_osc_en, osc32_en}, 5'h1F);

    // R2 idle entry and outputs
    wr(8'h0D);
    chk(mode_oh == IDLE, "R2 mode", mode_oh, IDLE);
    chk({cpu_clk_en, t2_clk_en, t2_hold_rst, pwm_hold_rst, adc_abort,
         periph_clk_en, hf_osc_en, osc32_en} == 8'b00111111, "R2 outs",
        {cpu_clk_en, t2_clk_en, t2_hold_rst, pwm_hold_rst, adc_abort,
         periph_clk_en, hf_osc_en, osc32_en}, 8'b00111111);
    // R11 write ignored in IDLE
    wr(8'h12);
    chk(mode_oh == IDLE && ctl_q == 8'h0D, "R11 idle write", ctl_q, 8'h0D);
    irq_req[4] = 1; irq_en[4] = 1; step();
    chk(mode_oh == RUN && ctl_q == 8'h0C, "R12 exit flags", ctl_q, 8'h0C);
    quiet();

    // R3/R12 randomized idle wake
    for (int it = 0; it < 40; it++) begin
      fl = 2'($urandom);
      wr({4'h0, fl, 2'b01});
      chk(mode_oh == IDLE, "R2 rnd entry", mode_oh, IDLE);
      irq_req = NSRC'($urandom); irq_en = NSRC'($urandom); irq_prio = NSRC'($urandom);
      insvc_lo = 1'($urandom); insvc_hi = ($urandom % 4) == 0;
      w = exp_idle_wake(irq_req, irq_en, irq_prio, insvc_lo, insvc_hi);
      step();
      chk(mode_oh == (w ? RUN : IDLE), "R3 wake", mode_oh, w ? RUN : IDLE);
      chk(ctl_q[3:0] == {fl, 1'b0, !w}, "R12 flags", ctl_q[3:0], {fl, 1'b0, !w});
      if (!w) begin
        quiet(); irq_req[0] = 1; irq_en[0] = 1; step();
        chk(mode_oh == RUN, "R3 unblocked wake", mode_oh, RUN);
      end
      quiet();
    end

    // R4 watchdog blocks power-down, both bits
    wdt_en = 1; wr(8'h03);
    chk(mode_oh == IDLE && ctl_q[1:0] == 2'b01, "R4 wdt block", {mode_oh, ctl_q[1:0]}, {IDLE, 2'b01});
    irq_req[1] = 1; irq_en[1] = 1; step(); quiet();
    wdt_en = 0; wr(8'h03);
    chk(mode_oh == PDN && ctl_q[1:0] == 2'b10, "R4 pd wins", {mode_oh, ctl_q[1:0]}, {PDN, 2'b10});
    irq_req[2] = 1; irq_en[2] = 1; step(); quiet();
    chk(mode_oh == RUN && ctl_q[1] == 0, "R6 X1 wake", mode_oh, RUN);

    // R5 oscillator rules
    sel_hf = 0; wr(8'h12);
    chk({cpu_clk_en, t2_clk_en, periph_clk_en, hf_osc_en, osc32_en} == 5'b00001,
        "R5 pll run32", {cpu_clk_en, t2_clk_en, periph_clk_en, hf_osc_en, osc32_en}, 5'b00001);
    sel_hf = 1; #1;
    chk(osc32_en == 0, "R5 hf osc32 off", osc32_en, 0);
    sel_hf = 0; #1;
    chk(osc32_en == 1, "R5 pll osc32 on", osc32_en, 1);
    irq_req[3] = 1; irq_en[3] = 1; step(); quiet();
    chk(mode_oh == RUN, "R6 SEC wake", mode_oh, RUN);
    wr(8'h02);
    chk(osc32_en == 0, "R5 no run32", osc32_en, 0);
    irq_req[0] = 1; irq_en[0] = 1; step(); quiet();

    // R6/R7 randomized power-down wake
    for (int it = 0; it < 30; it++) begin
      isr = ($urandom % 3) == 0;
      insvc_lo = isr;
      wr(8'h02);
      chk(mode_oh == PDN, "R4 pd entry", mode_oh, PDN);
      insvc_lo = 0;
      irq_req = NSRC'($urandom); irq_en = NSRC'($urandom);
      w = exp_pd_wake(irq_req, irq_en, isr);
      step();
      chk(mode_oh == (w ? RUN : PDN), isr ? "R7 isr refuse" : "R6 pd wake",
          mode_oh, w ? RUN : PDN);
      quiet();
      if (!w) begin
        if (isr) begin
          wdt_rst = 1; step(); wdt_rst = 0; restart_len(len);
        end else begin
          irq_req[3] = 1; irq_en[3] = 1; step(); quiet();
        end
        chk(mode_oh == RUN, "R6 recover", mode_oh, RUN);
      end
    end

    // R8 HF external reset width
    sel_hf = 1; wr(8'h0D);
    ext_rst = 1; step(HF_RST - 1);
    chk(mode_oh == IDLE, "R8 early", mode_oh, IDLE);
    step();
    chk(mode_oh == RSTR && core_rst, "R8 accept", mode_oh, RSTR);
    ext_rst = 0;
    restart_len(len);
    chk(len == HF_RS, "R10 hf len", len, HF_RS);
    chk(mode_oh == RUN && ctl_q == 0, "R10 ctl cleared", ctl_q, 0);

    // R9 PLL window
    sel_hf = 0;
    ext_rst = 1; step(PLL_MIN - 1); ext_rst = 0; step(2);
    chk(mode_oh == RUN, "R9 short", mode_oh, RUN);
    ext_rst = 1; step(PLL_MAX + 1); ext_rst = 0; step(2);
    chk(mode_oh == RUN, "R9 long", mode_oh, RUN);
    wr(8'h02);
    ext_rst = 1; step(PLL_MAX); ext_rst = 0;
    chk(mode_oh == PDN, "R9 held", mode_oh, PDN);
    step();
    chk(mode_oh == RSTR, "R9 accept max", mode_oh, RSTR);
    restart_len(len);
    chk(len == PLL_RS, "R10 pll len", len, PLL_RS);
    ext_rst = 1; step(PLL_MIN); ext_rst = 0; step();
    chk(mode_oh == RSTR, "R9 accept min", mode_oh, RSTR);
    restart_len(len);

    // R10 watchdog restart from idle
    wr(8'h05);
    wdt_rst = 1; step(); wdt_rst = 0;
    chk(mode_oh == RSTR && ctl_q == 0, "R10 wdt", mode_oh, RSTR);
    restart_len(len);
    chk(len == WDT_RS, "R10 wdt len", len, WDT_RS);
    wr(8'h04);
    chk(mode_oh == RUN && ctl_q == 8'h04, "R11 run write", ctl_q, 8'h04);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule